// File: doc/BRIEF.md
# Serial Programming Command Engine

This block drives the bit-level side of a two-wire serial programming link: one clock line it always drives and one data line it drives or releases. A host hands it an operation type, a 4-bit command code and a 16-bit operand through a valid/ready handshake. The engine clocks the fields out, inserts the required idle gaps and turns the data line around for reads. For a programming command it stretches one clock pulse so that the target can finish a self-timed flash write. Completion of every operation is marked by a single-cycle done strobe, and a read also delivers the byte it collected.

Timing is given in system clock cycles through parameters: the clock half-period (`HALF_CYC`), the inter-field gap (`GAP_CYC`), the programming hold (`PROG_CYC`) and the erase wait (`ERASE_CYC`). Operation codes on `req_op_i` are: 0 write, 1 read, 2 write-and-program, 3 erase. Sequencing such as pointer loading, erase flows and image handling belongs to the host.

Top module: `serprog_engine`

## Requirements
- R1: After reset `req_ready_o`=1, `sclk_o`=0, `sdo_o`=0, `sdo_oe_o`=1, `done_o`=0 and `rdata_o`=0.
- R2: A write (op 0) gives 20 clocks. The first 4 carry `req_cmd_i` LSB first and the next 16 carry `req_opnd_i` LSB first, so the low byte goes before the high byte. Each bit is set up while the clock is low and stays stable while it is high.
- R3: Between the last command clock and the first operand clock, the clock stays low for at least `GAP_CYC` cycles. A gap of at least `GAP_CYC` cycles also follows the operand before the operation completes.
- R4: A read (op 1) gives 4 command clocks and then 8 clocks with data 0. After a gap it gives 8 further clocks with the data line released. `sdi_i` is sampled once after each falling edge of those clocks, and the byte is assembled LSB first into `rdata_o`.
- R5: `sdo_oe_o` is 0 only from the end of the read's pre-turnaround gap to the end of its trailing gap, and it rises in the same cycle as `done_o`.
- R6: A write-and-program (op 2) sends command and operand as in R2, followed by a gap. It then gives 3 clocks with data 0 and a 4th clock held high for at least `PROG_CYC` cycles. After a low gap of at least `GAP_CYC` cycles come 16 clocks with data 0, for 40 clocks in total.
- R7: An erase (op 3) gives 4 clocks with data 0 whatever `req_cmd_i` and `req_opnd_i` hold. The clock then stays low for at least `ERASE_CYC` cycles, followed by 16 clocks with data 0.
- R8: A request is taken only while `req_ready_o` is 1, and `req_ready_o` is 0 from acceptance until completion. `req_valid_i` asserted while busy starts no operation.
- R9: Each accepted operation ends with exactly one `done_o` pulse, one cycle long.
- R10: Every clock pulse other than the stretched programming pulse is high for exactly `HALF_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request can be taken |
| req_op_i | input | 2 | Operation: 0 write, 1 read, 2 program, 3 erase |
| req_cmd_i | input | 4 | Command code |
| req_opnd_i | input | 16 | Operand |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 8 | Byte collected by the last read |
| sclk_o | output | 1 | Serial clock to target |
| sdo_o | output | 1 | Serial data to target |
| sdo_oe_o | output | 1 | Data line drive enable (1 = drive) |
| sdi_i | input | 1 | Serial data from target |

## Verification
The assertions assume that the timer lengths are non-zero, that requests are presented only through the handshake, and that `sdi_i` is meaningful only while the data line is released. The bench stays within these assumptions by keeping the default non-zero timings. It drives `sdi_i` from a target model that changes data only on a falling clock edge while `sdo_oe_o` is low. While a transfer runs it raises `req_valid_i` only to check that the request is ignored.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD,
    S_GAP1,
    S_OPND,
    S_GAP2,
    S_RECV,
    S_GAP3,
    S_PZ3,
    S_PLOW,
    S_PHIGH,
    S_GAP4,
    S_PTAIL,
    S_GAP5
  } state_e;

  localparam int CMD_BITS  = 4;
  localparam int OPND_BITS = 16;
  localparam int RD_BITS   = 8;
  localparam int PZ_BITS   = 3;
  localparam int TAIL_BITS = 16;
  localparam int BCNT_W    = $clog2(OPND_BITS + 1);

endpackage

// File: rtl/serprog_wait_timer.sv
module serprog_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expire_o
);

  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= len_i - TW'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - TW'(1);
    end
  end

  // expire in the cycle the requested length has elapsed
  assign expire_o = run_q && (cnt_q == '0);

  // R3
  timer_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0));

endmodule

// File: rtl/serprog_bit_clock.sv
module serprog_bit_clock #(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rd_shape_i,
  output logic sclk_o,
  output logic cell_end_o
);

  localparam int CW = $clog2(2 * HALF_CYC);
  localparam logic [CW-1:0] LAST = CW'(2 * HALF_CYC - 1);
  localparam logic [CW-1:0] HALF = CW'(HALF_CYC);

  logic [CW-1:0] cnt_q;
  logic          second_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CW'(1);
  end

  assign second_half = (cnt_q >= HALF);
  // write cell: low then high; read cell: high then low, sample at its end
  assign sclk_o     = en_i && (rd_shape_i ? !second_half : second_half);
  assign cell_end_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/serprog_engine.sv
module serprog_engine
  import serprog_pkg::*;
#(
  parameter int HALF_CYC  = 2,
  parameter int GAP_CYC   = 4,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [1:0]  req_op_i,
  input  logic [3:0]  req_cmd_i,
  input  logic [15:0] req_opnd_i,
  output logic        done_o,
  output logic [7:0]  rdata_o,
  output logic        sclk_o,
  output logic        sdo_o,
  output logic        sdo_oe_o,
  input  logic        sdi_i
);

  localparam int MAXW = (ERASE_CYC > PROG_CYC) ?
                        ((ERASE_CYC > GAP_CYC) ? ERASE_CYC : GAP_CYC) :
                        ((PROG_CYC > GAP_CYC) ? PROG_CYC : GAP_CYC);
  localparam int TW = $clog2(MAXW + 1) + 1;

  state_e                     state_q, state_d;
  op_e                        op_q;
  logic [OPND_BITS-1:0]       opnd_q;
  logic [OPND_BITS-1:0]       shreg_q, shreg_val;
  logic [BCNT_W-1:0]          bits_q, bits_val;
  logic [RD_BITS-1:0]         rbuf_q;
  logic                       done_q;
  logic                       ld_shreg, ld_bits, fin;
  logic                       tmr_load, tmr_exp;
  logic [TW-1:0]              tmr_len;
  logic                       shift_st, recv_st, bclk_en, bclk_sclk, cell_end, last_bit;
  logic                       accept;

  assign accept   = req_valid_i && (state_q == S_IDLE);
  assign shift_st = (state_q == S_CMD) || (state_q == S_OPND) ||
                    (state_q == S_PZ3) || (state_q == S_PTAIL);
  assign recv_st  = (state_q == S_RECV);
  assign bclk_en  = shift_st || recv_st;
  assign last_bit = cell_end && (bits_q == BCNT_W'(1));

  serprog_bit_clock #(.HALF_CYC(HALF_CYC)) u_bclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (bclk_en),
    .rd_shape_i (recv_st),
    .sclk_o     (bclk_sclk),
    .cell_end_o (cell_end)
  );

  serprog_wait_timer #(.TW(TW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_exp)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_len   = TW'(GAP_CYC);
    ld_shreg  = 1'b0;
    shreg_val = '0;
    ld_bits   = 1'b0;
    bits_val  = '0;
    fin       = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid_i) begin
        state_d   = S_CMD;
        ld_shreg  = 1'b1;
        shreg_val = (op_e'(req_op_i) == OP_ERASE) ? '0 : OPND_BITS'(req_cmd_i);
        ld_bits   = 1'b1;
        bits_val  = BCNT_W'(CMD_BITS);
      end
      S_CMD: if (last_bit) begin
        state_d  = S_GAP1;
        tmr_load = 1'b1;
        tmr_len  = (op_q == OP_ERASE) ? TW'(ERASE_CYC) : TW'(GAP_CYC);
      end
      S_GAP1: if (tmr_exp) begin
        state_d   = S_OPND;
        ld_shreg  = 1'b1;
        shreg_val = (op_q == OP_WRITE || op_q == OP_PROG) ? opnd_q : '0;
        ld_bits   = 1'b1;
        bits_val  = (op_q == OP_READ) ? BCNT_W'(RD_BITS) : BCNT_W'(OPND_BITS);
      end
      S_OPND: if (last_bit) begin
        state_d  = S_GAP2;
        tmr_load = 1'b1;
      end
      S_GAP2: if (tmr_exp) begin
        ld_bits  = 1'b1;
        ld_shreg = 1'b1;
        case (op_q)
          OP_READ: begin
            state_d  = S_RECV;
            bits_val = BCNT_W'(RD_BITS);
          end
          OP_PROG: begin
            state_d  = S_PZ3;
            bits_val = BCNT_W'(PZ_BITS);
          end
          default: begin
            state_d = S_IDLE;
            fin     = 1'b1;
          end
        endcase
      end
      S_RECV: if (last_bit) begin
        state_d  = S_GAP3;
        tmr_load = 1'b1;
      end
      S_GAP3: if (tmr_exp) begin
        state_d = S_IDLE;
        fin     = 1'b1;
      end
      S_PZ3: if (last_bit) begin
        state_d  = S_PLOW;
        tmr_load = 1'b1;
        tmr_len  = TW'(HALF_CYC);
      end
      S_PLOW: if (tmr_exp) begin
        state_d  = S_PHIGH;
        tmr_load = 1'b1;
        tmr_len  = TW'(PROG_CYC);
      end
      S_PHIGH: if (tmr_exp) begin
        state_d  = S_GAP4;
        tmr_load = 1'b1;
      end
      S_GAP4: if (tmr_exp) begin
        state_d  = S_PTAIL;
        ld_shreg = 1'b1;
        ld_bits  = 1'b1;
        bits_val = BCNT_W'(TAIL_BITS);
      end
      S_PTAIL: if (last_bit) begin
        state_d  = S_GAP5;
        tmr_load = 1'b1;
      end
      S_GAP5: if (tmr_exp) begin
        state_d = S_IDLE;
        fin     = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_WRITE;
      opnd_q  <= '0;
      shreg_q <= '0;
      bits_q  <= '0;
      rbuf_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (accept) begin
        op_q   <= op_e'(req_op_i);
        opnd_q <= req_opnd_i;
      end
      if (ld_shreg)                  shreg_q <= shreg_val;
      else if (shift_st && cell_end) shreg_q <= shreg_q >> 1;
      if (ld_bits)       bits_q <= bits_val;
      else if (cell_end) bits_q <= bits_q - BCNT_W'(1);
      if (recv_st && cell_end) rbuf_q <= {sdi_i, rbuf_q[RD_BITS-1:1]};
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rbuf_q;
  assign sclk_o      = bclk_sclk || (state_q == S_PHIGH);
  assign sdo_o       = shift_st ? shreg_q[0] : 1'b0;
  assign sdo_oe_o    = !((state_q == S_RECV) || (state_q == S_GAP3));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!sclk_o && sdo_oe_o));

  // R2
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

  // R5
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> done_o);

  // R8
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/serprog_engine_bench.sv
`timescale 1ns/1ps
module serprog_engine_bench;

  localparam int HALF = 2;
  localparam int GAP  = 4;
  localparam int PROG = 20;
  localparam int ERS  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [3:0]  cmd = 4'd0;
  logic [15:0] opnd = 16'd0;
  logic        ready, done, sclk, sdo, oe;
  logic [7:0]  rdata;
  logic        sdi = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  // monitor state
  int   n_rise = 0;
  int   n_done = 0;
  int   ridx = 0;
  int   rbase = 0;
  int   low_cnt = 0;
  int   high_cnt = 0;
  logic prev_sclk = 1'b0;
  logic [7:0] rd_pat = 8'h00;
  logic rise_sdo [512];
  logic rise_oe  [512];
  int   low_len  [512];
  int   high_len [512];

  always #5 clk = ~clk;

  serprog_engine #(.HALF_CYC(HALF), .GAP_CYC(GAP), .PROG_CYC(PROG), .ERASE_CYC(ERS)) u_serprog_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_op_i(op), .req_cmd_i(cmd), .req_opnd_i(opnd), .done_o(done),
    .rdata_o(rdata), .sclk_o(sclk), .sdo_o(sdo), .sdo_oe_o(oe), .sdi_i(sdi)
  );

  // line monitor and target model, sampled mid-cycle
  always @(negedge clk) begin
    if (done) n_done++;
    if (sclk && !prev_sclk) begin
      rise_sdo[n_rise] = sdo;
      rise_oe[n_rise]  = oe;
      low_len[n_rise]  = low_cnt;
      n_rise++;
      high_cnt = 1;
    end else if (sclk) begin
      high_cnt++;
    end else if (prev_sclk) begin
      high_len[n_rise-1] = high_cnt;
      low_cnt = 1;
      if (!oe) begin
        sdi = rd_pat[3'(ridx - rbase)];
        ridx++;
      end
    end else begin
      low_cnt++;
    end
    prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one request and wait for its completion
  task automatic run_op(input logic [1:0] o, input logic [3:0] c, input logic [15:0] d,
                        output int base, output int dbase);
    int guard;
    base  = n_rise;
    dbase = n_done;
    @(negedge clk);
    valid = 1'b1; op = o; cmd = c; opnd = d;
    @(negedge clk);
    valid = 1'b0;
    guard = 0;
    while (n_done == dbase && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, "R9 watchdog", guard, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_halves(input int base, input int n, input int skip, input string req);
    for (int i = 0; i < n; i++)
      if (i != skip) check(high_len[base+i] == HALF, req, high_len[base+i], HALF);
  endtask

  task automatic t_reset();
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(!sclk && !sdo, "R1 lines", {sclk, sdo}, 0);
    check(oe == 1'b1 && !done, "R1 oe/done", {oe, done}, 2);
    check(rdata == 8'h00, "R1 rdata", rdata, 0);
  endtask

  task automatic t_write(input logic [3:0] c, input logic [15:0] d);
    int b, db;
    logic [19:0] got;
    run_op(2'd0, c, d, b, db);
    check(n_rise - b == 20, "R2 clock count", n_rise - b, 20);
    for (int i = 0; i < 20; i++) got[i] = rise_sdo[b+i];
    check(got == {d, c}, "R2 bit order", got, {d, c});
    check(low_len[b+4] >= GAP, "R3 cmd gap", low_len[b+4], GAP);
    check(n_done - db == 1, "R9 done pulse", n_done - db, 1);
    chk_halves(b, 20, -1, "R10 half period");
  endtask

  task automatic t_read(input logic [3:0] c, input logic [7:0] pat);
    int b, db;
    logic [11:0] got;
    logic        oe_drv, oe_rel;
    rd_pat = pat;
    rbase  = ridx;
    run_op(2'd1, c, 16'hFFFF, b, db);
    check(n_rise - b == 20, "R4 clock count", n_rise - b, 20);
    oe_drv = 1'b1; oe_rel = 1'b0;
    for (int i = 0; i < 12; i++) begin
      got[i] = rise_sdo[b+i];
      oe_drv &= rise_oe[b+i];
    end
    for (int i = 12; i < 20; i++) oe_rel |= rise_oe[b+i];
    check(got == {8'h00, c}, "R4 cmd and zero byte", got, {8'h00, c});
    check(rdata == pat, "R4 read byte", rdata, pat);
    check(oe_drv && !oe_rel, "R5 oe window", {oe_drv, oe_rel}, 2);
    check(oe == 1'b1, "R5 oe after done", oe, 1);
    check(low_len[b+12] >= GAP, "R3 turnaround gap", low_len[b+12], GAP);
    check(n_done - db == 1, "R9 done pulse", n_done - db, 1);
  endtask

  task automatic t_prog(input logic [3:0] c, input logic [15:0] d);
    int b, db;
    logic [39:0] got;
    run_op(2'd2, c, d, b, db);
    check(n_rise - b == 40, "R6 clock count", n_rise - b, 40);
    for (int i = 0; i < 40; i++) got[i] = rise_sdo[b+i];
    check(got == {20'h0, d, c}, "R6 bits", got, {20'h0, d, c});
    check(high_len[b+23] >= PROG, "R6 stretched pulse", high_len[b+23], PROG);
    check(low_len[b+24] >= GAP, "R6 gap after pulse", low_len[b+24], GAP);
    chk_halves(b, 40, 23, "R10 half period");
  endtask

  task automatic t_erase(input logic [3:0] c, input logic [15:0] d);
    int b, db;
    logic [19:0] got;
    run_op(2'd3, c, d, b, db);
    check(n_rise - b == 20, "R7 clock count", n_rise - b, 20);
    for (int i = 0; i < 20; i++) got[i] = rise_sdo[b+i];
    check(got == 20'h0, "R7 zero bits", got, 0);
    check(low_len[b+4] >= ERS, "R7 erase wait", low_len[b+4], ERS);
  endtask

  task automatic t_busy();
    int b, db, guard;
    b  = n_rise;
    db = n_done;
    @(negedge clk);
    valid = 1'b1; op = 2'd0; cmd = 4'h5; opnd = 16'h00F0;
    @(negedge clk);
    valid = 1'b0;
    repeat (3) @(negedge clk);
    check(ready == 1'b0, "R8 ready low while busy", ready, 0);
    valid = 1'b1; op = 2'd2; cmd = 4'hF; opnd = 16'hFFFF;
    repeat (8) @(negedge clk);
    valid = 1'b0;
    guard = 0;
    while (n_done == db && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (150) @(negedge clk);
    check(n_rise - b == 20, "R8 busy request ignored", n_rise - b, 20);
    check(n_done - db == 1, "R8 single completion", n_done - db, 1);
    check(ready == 1'b1, "R8 ready after done", ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(4'hD, 16'hA53C);
    t_write(4'h0, 16'h0001);
    t_read(4'h9, 8'hB4);
    t_read(4'h2, 8'h81);
    t_prog(4'hF, 16'h1234);
    t_erase(4'hA, 16'hFFFF);
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule